// File: doc/BRIEF.md
# Pad Boundary-Scan Register Segment

This block is one slice of a boundary-scan register, sitting between the core logic and a small group of bidirectional pads. Each pad has three scan cells: an enable cell, a data-out cell and a data-in cell. Each cell has a shift stage and an update stage. An external test controller supplies the scan input, a mode code and three strobes: capture, shift and update. The slice returns a serial scan output.

In functional mode the slice is transparent and passes core and pad signals straight through. In the test modes, a capture loads the live core and pad values into the shift stage. Shifting then moves those values toward the scan output while a new word enters from the scan input. An update copies the shifted word into the update stage. Depending on the mode, the update stage then drives the pads (external test), drives both the pads and the core inputs (internal test), or only waits (sample and preload). The pad drivers themselves are outside the block. A pad counts as high-impedance whenever `pad_oe` is low.

Top module: `bsr_pad_segment`

## Requirements
- R1: After reset, the shift stage and `scan_out` are 0. The update stage holds 1 in every enable cell and 0 in every data cell, so in external-test mode `pad_oe` and `pad_dout` are all 0.
- R2: `mode_sel` codes: 0 functional, 1 sample, 2 preload, 3 external test, 4 internal test. Codes 5 to 7 act as functional. In functional, sample and preload modes, `pad_oe`=`core_oe`, `pad_dout`=`core_dout` and `core_din`=`pad_din`.
- R3: Cell k of pad p has chain index 3p+k. Index 0 is nearest the scan input and index 3·NPADS-1 is the last cell. A capture strobe in a test mode loads the enable cell with the inverse of `core_oe[p]`, the data-out cell with `core_dout[p]` and the data-in cell with `pad_din[p]`.
- R4: A shift strobe in a test mode moves every cell one place toward the last cell and loads index 0 from `scan_in`. On that same edge, `scan_out` takes the bit leaving the last cell. `scan_out` changes on no other cycle.
- R5: The update stage loads the whole shift stage on an update strobe in a test mode and holds its value otherwise, including while shifting.
- R6: In external-test mode, `pad_oe[p]` is the inverse of the updated enable cell, so a 1 makes the pad high-impedance, and `pad_dout[p]` is the updated data-out cell. `core_din` still follows `pad_din`.
- R7: In internal-test mode, the pads are driven as in R6 and `core_din[p]` is the updated data-in cell.
- R8: In sample and preload modes, capture, shift and update leave the pins in their functional state.
- R9: In functional mode the three strobes are ignored: the shift stage, the update stage and `scan_out` all hold.
- R10: When capture and shift are strobed together, the capture takes effect and no shift happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode code (see R2) |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial scan input |
| scan_out | output | 1 | Serial scan output (registered) |
| core_oe | input | NPADS | Core output enables, 1 = drive |
| core_dout | input | NPADS | Core output data |
| core_din | output | NPADS | Data delivered to the core |
| pad_din | input | NPADS | Values seen at the pads |
| pad_oe | output | NPADS | Pad driver enable, 0 = high-impedance |
| pad_dout | output | NPADS | Pad driver data |

## Verification
The pin outputs are combinational from the mode code and the update stage. They are therefore checked at the falling edge after the mode change or after the update strobe's rising edge. A capture is seen one edge after its strobe, and each shifted bit appears on `scan_out` one edge after its shift strobe. The bench drives every strobe at a falling edge and reads `scan_out` at the next falling edge, so bit 3·NPADS-1-k of the captured word is collected after shift k. The hold cases (R5, R9) are read back through the ports: pin values are checked before an update, and after functional-mode strobes the old word is shifted out.

// File: rtl/bsr_seg_pkg.sv
package bsr_seg_pkg;
  typedef enum logic [2:0] {
    BM_FUNC    = 3'd0,
    BM_SAMPLE  = 3'd1,
    BM_PRELOAD = 3'd2,
    BM_EXTEST  = 3'd3,
    BM_INTEST  = 3'd4
  } bsr_mode_e;

  localparam int CELLS_PER_PAD = 3;
  localparam int CTL_OFS = 0;
  localparam int OUT_OFS = 1;
  localparam int IN_OFS  = 2;

  function automatic int cell_idx(int pad, int ofs);
    return pad * CELLS_PER_PAD + ofs;
  endfunction

  function automatic logic is_test(logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction

  function automatic logic drives_pads(logic [2:0] m);
    return (m == BM_EXTEST) || (m == BM_INTEST);
  endfunction

  function automatic logic drives_core(logic [2:0] m);
    return m == BM_INTEST;
  endfunction
endpackage

// File: rtl/bsr_shift_chain.sv
module bsr_shift_chain #(
  parameter int LEN = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_load,
  input  logic           shift_step,
  input  logic [LEN-1:0] cap_vec,
  input  logic           scan_in,
  output logic [LEN-1:0] chain_q,
  output logic           scan_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q  <= '0;
      scan_out <= 1'b0;
    end else if (cap_load) begin
      chain_q <= cap_vec;
    end else if (shift_step) begin
      chain_q  <= {chain_q[LEN-2:0], scan_in};
      scan_out <= chain_q[LEN-1];
    end
  end

  // R4
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_step |=> (chain_q[0] == $past(scan_in)) && (scan_out == $past(chain_q[LEN-1])));
  // R4
  scan_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_step |=> $stable(scan_out));
  // R3
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_load |=> chain_q == $past(cap_vec));
endmodule

// File: rtl/bsr_update_stage.sv
module bsr_update_stage
  import bsr_seg_pkg::*;
#(
  parameter int NPADS = 4,
  localparam int LEN = NPADS * CELLS_PER_PAD
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_load,
  input  logic [LEN-1:0] chain_q,
  output logic [LEN-1:0] upd_q
);
  logic [LEN-1:0] safe_val;

  for (genvar p = 0; p < NPADS; p++) begin : g_safe
    assign safe_val[cell_idx(p, CTL_OFS)] = 1'b1;
    assign safe_val[cell_idx(p, OUT_OFS)] = 1'b0;
    assign safe_val[cell_idx(p, IN_OFS)]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        upd_q <= safe_val;
    else if (upd_load) upd_q <= chain_q;
  end

  // R5
  upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_load |=> $stable(upd_q));
  // R5
  upd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_load |=> upd_q == $past(chain_q));
endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux
  import bsr_seg_pkg::*;
#(
  parameter int NPADS = 4,
  localparam int LEN = NPADS * CELLS_PER_PAD
) (
  input  logic [2:0]       mode_sel,
  input  logic [LEN-1:0]   upd_q,
  input  logic [NPADS-1:0] core_oe,
  input  logic [NPADS-1:0] core_dout,
  input  logic [NPADS-1:0] pad_din,
  output logic [LEN-1:0]   cap_vec,
  output logic [NPADS-1:0] pad_oe,
  output logic [NPADS-1:0] pad_dout,
  output logic [NPADS-1:0] core_din
);
  logic to_pads, to_core;
  assign to_pads = drives_pads(mode_sel);
  assign to_core = drives_core(mode_sel);

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    assign cap_vec[cell_idx(p, CTL_OFS)] = ~core_oe[p];
    assign cap_vec[cell_idx(p, OUT_OFS)] = core_dout[p];
    assign cap_vec[cell_idx(p, IN_OFS)]  = pad_din[p];

    assign pad_oe[p]   = to_pads ? ~upd_q[cell_idx(p, CTL_OFS)] : core_oe[p];
    assign pad_dout[p] = to_pads ?  upd_q[cell_idx(p, OUT_OFS)] : core_dout[p];
    assign core_din[p] = to_core ?  upd_q[cell_idx(p, IN_OFS)]  : pad_din[p];
  end
endmodule

// File: rtl/bsr_pad_segment.sv
module bsr_pad_segment
  import bsr_seg_pkg::*;
#(
  parameter int NPADS = 4,
  localparam int LEN = NPADS * CELLS_PER_PAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_sel,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [NPADS-1:0] core_oe,
  input  logic [NPADS-1:0] core_dout,
  output logic [NPADS-1:0] core_din,
  input  logic [NPADS-1:0] pad_din,
  output logic [NPADS-1:0] pad_oe,
  output logic [NPADS-1:0] pad_dout
);
  logic           test_mode, cap_load, shift_step, upd_load;
  logic [LEN-1:0] cap_vec, chain_q, upd_q;

  assign test_mode  = is_test(mode_sel);
  assign cap_load   = test_mode & capture_en;
  assign shift_step = test_mode & shift_en & ~capture_en;
  assign upd_load   = test_mode & update_en;

  bsr_pad_mux #(.NPADS(NPADS)) mux_i (
    .mode_sel(mode_sel), .upd_q(upd_q), .core_oe(core_oe),
    .core_dout(core_dout), .pad_din(pad_din), .cap_vec(cap_vec),
    .pad_oe(pad_oe), .pad_dout(pad_dout), .core_din(core_din)
  );

  bsr_shift_chain #(.LEN(LEN)) chain_i (
    .clk(clk), .rst_n(rst_n), .cap_load(cap_load), .shift_step(shift_step),
    .cap_vec(cap_vec), .scan_in(scan_in), .chain_q(chain_q), .scan_out(scan_out)
  );

  bsr_update_stage #(.NPADS(NPADS)) upd_i (
    .clk(clk), .rst_n(rst_n), .upd_load(upd_load),
    .chain_q(chain_q), .upd_q(upd_q)
  );

  // R9
  func_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> $stable(chain_q) && $stable(upd_q) && $stable(scan_out));
  // R10
  cap_over_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && capture_en && shift_en) |=> $stable(scan_out));
  // R2
  transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drives_pads(mode_sel) |-> (pad_oe == core_oe) && (pad_dout == core_dout) && (core_din == pad_din));
endmodule

// File: tb/bsr_pad_segment_tb_top.sv
`timescale 1ns/1ps
module bsr_pad_segment_tb_top;
  localparam int NP = 4;
  localparam int L  = 3 * NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic capture_en = 0, shift_en = 0, update_en = 0, scan_in = 0;
  logic scan_out;
  logic [NP-1:0] core_oe = '0, core_dout = '0, pad_din = '0;
  logic [NP-1:0] core_din, pad_oe, pad_dout;

  int checks = 0;
  int fails = 0;
  logic [L-1:0] exp_upd;

  always #10 clk = ~clk;

  bsr_pad_segment #(.NPADS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .scan_in(scan_in),
    .scan_out(scan_out), .core_oe(core_oe), .core_dout(core_dout),
    .core_din(core_din), .pad_din(pad_din), .pad_oe(pad_oe), .pad_dout(pad_dout)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [L-1:0] model_capture(logic [NP-1:0] oe, logic [NP-1:0] d, logic [NP-1:0] pin);
    logic [L-1:0] w;
    for (int p = 0; p < NP; p++) begin
      w[3*p]   = !oe[p];
      w[3*p+1] = d[p];
      w[3*p+2] = pin[p];
    end
    return w;
  endfunction

  task automatic check_pins(string tag);
    logic [NP-1:0] e_oe, e_do, e_cd;
    logic ext, intl;
    ext  = (mode_sel == 3'd3) || (mode_sel == 3'd4);
    intl = (mode_sel == 3'd4);
    for (int p = 0; p < NP; p++) begin
      e_oe[p] = ext ? !exp_upd[3*p] : core_oe[p];
      e_do[p] = ext ? exp_upd[3*p+1] : core_dout[p];
      e_cd[p] = intl ? exp_upd[3*p+2] : pad_din[p];
    end
    chk({tag, " pad_oe"}, 64'(pad_oe), 64'(e_oe));
    chk({tag, " pad_dout"}, 64'(pad_dout), 64'(e_do));
    chk({tag, " core_din"}, 64'(core_din), 64'(e_cd));
  endtask

  task automatic do_capture();
    capture_en = 1; @(negedge clk); capture_en = 0;
  endtask

  task automatic do_update();
    update_en = 1; @(negedge clk); update_en = 0;
  endtask

  task automatic scan_word(input logic [L-1:0] w, output logic [L-1:0] got);
    shift_en = 1;
    for (int k = 0; k < L; k++) begin
      scan_in = w[L-1-k];
      @(negedge clk);
      got[L-1-k] = scan_out;
    end
    shift_en = 0;
    scan_in = 0;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [L-1:0] got, w, cw;
    int unsigned seed;
    seed = $urandom(32'h5A17);
    for (int p = 0; p < NP; p++) exp_upd[3*p +: 3] = 3'b001;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    mode_sel = 3'd3; #1;
    chk("R1 pad_oe", 64'(pad_oe), 0);
    chk("R1 pad_dout", 64'(pad_dout), 0);
    chk("R1 scan_out", 64'(scan_out), 0);
    mode_sel = 3'd4; #1;
    chk("R1 core_din", 64'(core_din), 0);

    // R2 transparency in functional and reserved codes
    for (int i = 0; i < 6; i++) begin
      mode_sel = (i < 3) ? 3'd0 : 3'(5 + (i % 3));
      core_oe = NP'($urandom()); core_dout = NP'($urandom()); pad_din = NP'($urandom());
      @(negedge clk);
      check_pins("R2");
    end

    // Random test-mode cycles: R3 R4 R5 R6 R7 R8
    for (int it = 0; it < 40; it++) begin
      string rt;
      mode_sel = 3'(1 + ($urandom() % 4));
      rt = (mode_sel == 3'd3) ? "R6" : (mode_sel == 3'd4) ? "R7" : "R8";
      core_oe = NP'($urandom()); core_dout = NP'($urandom()); pad_din = NP'($urandom());
      cw = model_capture(core_oe, core_dout, pad_din);
      do_capture();
      w = L'($urandom());
      scan_word(w, got);
      chk("R3 R4 scanned capture", 64'(got), 64'(cw));
      check_pins({"R5 before update ", rt});
      do_update();
      exp_upd = w;
      check_pins({"R5 after update ", rt});
      pad_din = NP'($urandom()); core_oe = NP'($urandom()); core_dout = NP'($urandom());
      #1;
      check_pins(rt);
    end

    // R4 scan_out holds without shifting
    mode_sel = 3'd1;
    w = L'($urandom());
    scan_word(w, got);
    got[0] = scan_out;
    repeat (3) @(negedge clk);
    chk("R4 scan_out hold", 64'(scan_out), 64'(got[0]));

    // R6 directed: all enable cells 1 gives all pads high-impedance
    mode_sel = 3'd3;
    w = '1;
    scan_word(w, got);
    do_update(); exp_upd = w;
    chk("R6 all disabled", 64'(pad_oe), 0);
    w = '0;
    for (int p = 0; p < NP; p++) w[3*p+1] = 1'b1;
    scan_word(w, got);
    do_update(); exp_upd = w;
    chk("R6 all driven oe", 64'(pad_oe), 64'({NP{1'b1}}));
    chk("R6 all driven data", 64'(pad_dout), 64'({NP{1'b1}}));

    // R9 functional mode ignores strobes
    mode_sel = 3'd2;
    w = L'($urandom());
    scan_word(w, got);
    mode_sel = 3'd0;
    core_oe = NP'($urandom()); core_dout = NP'($urandom()); pad_din = NP'($urandom());
    got[0] = scan_out;
    capture_en = 1; shift_en = 1; update_en = 1; scan_in = 1;
    repeat (4) @(negedge clk);
    capture_en = 0; shift_en = 0; update_en = 0; scan_in = 0;
    chk("R9 scan_out", 64'(scan_out), 64'(got[0]));
    mode_sel = 3'd3; #1;
    check_pins("R9 update held");
    mode_sel = 3'd2;
    scan_word('0, got);
    chk("R9 shift stage held", 64'(got), 64'(w));

    // R10 capture wins over shift
    mode_sel = 3'd1;
    core_oe = NP'($urandom()); core_dout = NP'($urandom()); pad_din = NP'($urandom());
    cw = model_capture(core_oe, core_dout, pad_din);
    got[0] = scan_out;
    capture_en = 1; shift_en = 1; scan_in = 1;
    @(negedge clk);
    capture_en = 0; shift_en = 0; scan_in = 0;
    chk("R10 scan_out unchanged", 64'(scan_out), 64'(got[0]));
    scan_word('0, got);
    chk("R10 captured word", 64'(got), 64'(cw));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule